// File: doc/BRIEF.md
# Watchdog Timer with Write-Locked Mode Register

This block supervises a system by counting ticks of a free-running low-speed clock that is independent of the system clock. Software (or any supervising logic timed by the tick) must pulse a refresh strobe before the count reaches the selected timeout. If it does not, the block pulls the system reset low at once, without needing a system clock edge. The timeout is one of four multiples of a base length, chosen by a two-bit field in a small mode register.

The mode register also holds a bit that decides whether the count keeps running while the system is in stop mode. The register can be written only during a short window of system clocks after each system reset. After that it locks until the next reset, so runaway code cannot disarm or stretch the watchdog. A power-on event holds the system reset for a fixed number of ticks after the power-on input releases. Every reset cause pulls the output low asynchronously. The output is released through a synchronizer on the system clock.

Top module: `wdog_guard`

## Requirements
- R1: The mode field cfg bits [1:0] select the timeout: 00 gives BASE_TICKS, 01 gives 2×, 10 gives 4× and 11 gives 16× BASE_TICKS tick-clock edges. The count runs from the last refresh edge to the edge that drives `rst_out_n` low.
- R2: A write on `mode_wr` is accepted on system clock edges 1 to WIN_CLKS (default 60), counted after `rst_out_n` rises. A write on edge WIN_CLKS+1 or later leaves `cfg_q` unchanged. `cfg_q` holds its value when no write occurs.
- R3: A tick edge that samples `kick` high clears the count to zero. This holds even on the edge where the count would expire, and no reset is produced on that edge.
- R4: On expiry, `rst_out_n` goes low without any system clock edge. It stays low while the system clock is stopped.
- R5: While `stop_mode` is high and cfg bit 2 is 0, the count is frozen. While cfg bit 2 is 1, the count keeps running in stop mode at the normal rate.
- R6: After `por_n` rises, `rst_out_n` stays low for POR_TICKS tick-clock edges.
- R7: Every system reset returns `cfg_q` to 000 and reopens the write window.
- R8: `rst_out_n` rises only on a system clock edge, SYNC_STAGES edges after every reset cause has cleared. `rst_ext_n` is a reset cause and also restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; may be stopped |
| rc_clk | input | 1 | Free-running watchdog tick clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| mode_wr | input | 1 | Mode register write strobe (clk_sys domain) |
| mode_wdata | input | 3 | Mode data: [1:0] timeout select, [2] run in stop mode |
| kick | input | 1 | Refresh strobe (rc_clk domain) |
| stop_mode | input | 1 | System is in stop mode |
| rst_out_n | output | 1 | System reset, active low |
| cfg_q | output | 3 | Current mode register contents |

## Verification
The bench times each of the four timeouts to the exact tick, so a select decoded as plain powers of two would fail on code 11 by firing at 8× instead of 16×. It writes on the last open clock and on the first closed one. An off-by-one window either drops the first write or accepts the second. A refresh placed on the expiry tick catches a design that lets expiry win. A run with the system clock stopped catches two faults: a reset that waits for a clock edge to assert, and a stop-mode freeze that ignores the run-in-stop bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       run_in_stop;
    logic [1:0] sel;
  } wdog_cfg_t;

  localparam int CFG_W = 3;

  // Timeout multiplier as a shift: 1x, 2x, 4x, 16x
  function automatic int sel_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_por.sv
module wdog_por #(
  parameter int POR_TICKS = 2048
) (
  input  logic rc_clk,
  input  logic por_n,
  output logic busy
);
  localparam int PW = $clog2(POR_TICKS + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != PW'(POR_TICKS));
    cnt_d  = cnt_q + PW'(1);
  end

  always_ff @(posedge rc_clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = cnt_en;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int BASE_TICKS = 4096,
  parameter int CNT_W      = $clog2(BASE_TICKS*16 + 1)
) (
  input  logic             rc_clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             kick,
  input  logic             run_en,
  input  logic [1:0]       sel,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             fire_q, fire_d;

  always_comb begin
    lim    = CNT_W'(BASE_TICKS) << wdog_pkg::sel_shift(sel);
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (kick) begin
      cnt_d = '0;
    end else if (hold) begin
      cnt_d = '0;
    end else if (run_en) begin
      if (cnt_q >= lim - CNT_W'(1)) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/wdog_mode.sv
module wdog_mode #(
  parameter int                          WIN_CLKS  = 60,
  parameter logic [wdog_pkg::CFG_W-1:0]  CFG_RESET = '0
) (
  input  logic                 clk_sys,
  input  logic                 rst_n,
  input  logic                 wr,
  input  wdog_pkg::wdog_cfg_t  wdata,
  output wdog_pkg::wdog_cfg_t  cfg
);
  localparam int WW = $clog2(WIN_CLKS + 1);

  logic [WW-1:0]       win_q, win_d;
  logic                win_open;
  wdog_pkg::wdog_cfg_t cfg_q, cfg_d;

  always_comb begin
    win_open = (win_q < WW'(WIN_CLKS));
    win_d    = win_open ? win_q + WW'(1) : win_q;
    cfg_d    = (wr && win_open) ? wdata : cfg_q;
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cfg_q <= CFG_RESET;
    end else begin
      win_q <= win_d;
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int STAGES = 2
) (
  input  logic clk_sys,
  input  logic req_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_sys or negedge req_n) begin
    if (!req_n) sh_q <= '0;
    else sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int          BASE_TICKS  = 4096,
  parameter int          POR_TICKS   = 2048,
  parameter int          WIN_CLKS    = 60,
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  CFG_RESET   = 3'b000
) (
  input  logic       clk_sys,
  input  logic       rc_clk,
  input  logic       por_n,
  input  logic       rst_ext_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_wdata,
  input  logic       kick,
  input  logic       stop_mode,
  output logic       rst_out_n,
  output logic [2:0] cfg_q
);
  localparam int CNT_W = $clog2(BASE_TICKS*16 + 1);

  wdog_pkg::wdog_cfg_t cfg;
  logic                cnt_rst_n;
  logic                stop_s;
  logic                cnt_run;
  logic                por_busy;
  logic                wdt_fire;
  logic                req_n;
  logic [CNT_W-1:0]    cnt_val;

  assign cnt_rst_n = por_n & rst_ext_n;
  assign cnt_run   = !stop_s || cfg.run_in_stop;
  assign req_n     = por_n & rst_ext_n & !por_busy & !wdt_fire;

  wdog_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk(rc_clk), .rst_n(cnt_rst_n), .d(stop_mode), .q(stop_s)
  );

  wdog_por #(.POR_TICKS(POR_TICKS)) u_por (
    .rc_clk(rc_clk), .por_n(por_n), .busy(por_busy)
  );

  wdog_count #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_cnt (
    .rc_clk(rc_clk), .rst_n(cnt_rst_n), .hold(por_busy), .kick(kick),
    .run_en(cnt_run), .sel(cfg.sel), .fire(wdt_fire), .cnt(cnt_val)
  );

  wdog_mode #(.WIN_CLKS(WIN_CLKS), .CFG_RESET(CFG_RESET)) u_mode (
    .clk_sys(clk_sys), .rst_n(rst_out_n), .wr(mode_wr),
    .wdata(mode_wdata), .cfg(cfg)
  );

  wdog_rstgen #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_sys(clk_sys), .req_n(req_n), .rst_n(rst_out_n)
  );

  assign cfg_q = cfg;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W    = 8,
  parameter int WIN_CLKS = 60
) (
  input logic             clk_sys,
  input logic             rc_clk,
  input logic             por_n,
  input logic             rst_ext_n,
  input logic             mode_wr,
  input logic             kick,
  input logic             rst_out_n,
  input logic [2:0]       cfg_q,
  input logic             wdt_fire,
  input logic             por_busy,
  input logic             cnt_run,
  input logic [CNT_W-1:0] cnt_val
);
  localparam int WW = $clog2(WIN_CLKS + 1);
  logic [WW-1:0] edges_q;

  always_ff @(posedge clk_sys or negedge rst_out_n) begin
    if (!rst_out_n) edges_q <= '0;
    else if (edges_q < WW'(WIN_CLKS)) edges_q <= edges_q + WW'(1);
  end

  assert_locked_write_R2: assert property (@(posedge clk_sys) disable iff (!rst_out_n)
    (edges_q >= WW'(WIN_CLKS) && mode_wr) |=> $stable(cfg_q));

  assert_cfg_idle_R2: assert property (@(posedge clk_sys) disable iff (!rst_out_n)
    !mode_wr |=> $stable(cfg_q));

  assert_kick_wins_R3: assert property (@(posedge rc_clk) disable iff (!(por_n && rst_ext_n))
    kick |=> !wdt_fire);

  assert_fire_resets_R4: assert property (@(posedge rc_clk) disable iff (!por_n)
    wdt_fire |-> !rst_out_n);

  assert_frozen_R5: assert property (@(posedge rc_clk) disable iff (!(por_n && rst_ext_n))
    (!cnt_run && !kick) |=> $stable(cnt_val));

  assert_por_hold_R6: assert property (@(posedge rc_clk) disable iff (!por_n)
    por_busy |-> !rst_out_n);

  assert_release_sync_R8: assert property (@(posedge clk_sys) disable iff (!por_n)
    $rose(rst_out_n) |-> (rst_ext_n && $past(rst_ext_n)));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W), .WIN_CLKS(WIN_CLKS)) u_chk (
  .clk_sys(clk_sys), .rc_clk(rc_clk), .por_n(por_n), .rst_ext_n(rst_ext_n),
  .mode_wr(mode_wr), .kick(kick), .rst_out_n(rst_out_n), .cfg_q(cfg_q),
  .wdt_fire(wdt_fire), .por_busy(por_busy), .cnt_run(cnt_run), .cnt_val(cnt_val)
);

// File: tb/tb_wdog_guard.sv
`timescale 1ns/1ps
module tb_wdog_guard;
  localparam int BASE = 16;
  localparam int PORT = 6;
  localparam int WIN  = 60;

  logic clk_sys = 1'b0, rc_clk = 1'b0, clk_run = 1'b1;
  logic por_n, rst_ext_n, mode_wr, kick, stop_mode, rst_out_n;
  logic [2:0] mode_wdata, cfg_q;
  int checks = 0, errors = 0;

  always begin #10; if (clk_run) clk_sys = ~clk_sys; end
  always #65 rc_clk = ~rc_clk;

  wdog_guard #(.BASE_TICKS(BASE), .POR_TICKS(PORT), .WIN_CLKS(WIN), .SYNC_STAGES(2)) dut (
    .clk_sys(clk_sys), .rc_clk(rc_clk), .por_n(por_n), .rst_ext_n(rst_ext_n),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .kick(kick), .stop_mode(stop_mode),
    .rst_out_n(rst_out_n), .cfg_q(cfg_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge rc_clk); rst_ext_n = 1'b0;
    repeat (2) @(negedge rc_clk); rst_ext_n = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_sys);
      if (rst_out_n) break;
    end
  endtask

  // Drive a write that the n-th clock edge after reset release samples
  task automatic write_at(input int n, input logic [2:0] d);
    repeat (n-1) @(negedge clk_sys);
    mode_wr = 1'b1; mode_wdata = d;
    @(negedge clk_sys); mode_wr = 1'b0;
  endtask

  task automatic do_kick();
    @(negedge rc_clk); kick = 1'b1;
    @(negedge rc_clk); kick = 1'b0;
  endtask

  task automatic check_expiry(input int lim, input string req);
    repeat (lim-1) @(negedge rc_clk);
    chk(rst_out_n === 1'b1, req, rst_out_n, 1);
    @(negedge rc_clk);
    chk(rst_out_n === 1'b0, req, rst_out_n, 0);
  endtask

  task automatic t_por();
    #50; chk(rst_out_n === 1'b0, "R6 reset state", rst_out_n, 0);
    @(negedge rc_clk); por_n = 1'b1;
    repeat (PORT-1) @(negedge rc_clk);
    chk(rst_out_n === 1'b0, "R6 stretch", rst_out_n, 0);
    @(negedge rc_clk);
    repeat (4) @(negedge clk_sys);
    chk(rst_out_n === 1'b1, "R8 release", rst_out_n, 1);
    chk(cfg_q === 3'b000, "R7 default cfg", cfg_q, 0);
  endtask

  task automatic t_selects();
    for (int s = 0; s < 4; s++) begin
      int mult;
      mult = (s == 3) ? 16 : (1 << s);
      do_reset();
      write_at(1, 3'(s));
      chk(cfg_q === 3'(s), "R2 first edge write", cfg_q, s);
      do_kick();
      check_expiry(BASE*mult, "R1 timeout length");
    end
  endtask

  task automatic t_window();
    do_reset();
    write_at(WIN, 3'b010);
    chk(cfg_q === 3'b010, "R2 last open edge", cfg_q, 2);
    write_at(1, 3'b011);
    chk(cfg_q === 3'b010, "R2 closed edge ignored", cfg_q, 2);
    do_kick();
    check_expiry(BASE*4, "R2 locked select");
    repeat (6) @(negedge clk_sys);
    chk(rst_out_n === 1'b1 && cfg_q === 3'b000, "R7 cfg after wdt reset", cfg_q, 0);
    write_at(1, 3'b001);
    chk(cfg_q === 3'b001, "R7 window reopened", cfg_q, 1);
  endtask

  task automatic t_priority();
    do_reset();
    do_kick();
    repeat (BASE-1) @(negedge rc_clk);
    kick = 1'b1;
    @(negedge rc_clk); kick = 1'b0;
    chk(rst_out_n === 1'b1, "R3 kick beats expiry", rst_out_n, 1);
    check_expiry(BASE, "R3 count restarted");
  endtask

  task automatic t_stop_frozen();
    do_reset();
    stop_mode = 1'b1;
    @(negedge clk_sys); clk_run = 1'b0;
    repeat (4) @(negedge rc_clk);
    do_kick();
    repeat (3*BASE) @(negedge rc_clk);
    chk(rst_out_n === 1'b1, "R5 frozen in stop", rst_out_n, 1);
    stop_mode = 1'b0;
    repeat (BASE+4) @(negedge rc_clk);
    chk(rst_out_n === 1'b0, "R4 fires with clock stopped", rst_out_n, 0);
    repeat (5) @(negedge rc_clk);
    chk(rst_out_n === 1'b0, "R4 held while clock stopped", rst_out_n, 0);
    clk_run = 1'b1;
    repeat (4) @(negedge clk_sys);
    chk(rst_out_n === 1'b1, "R8 release after restart", rst_out_n, 1);
  endtask

  task automatic t_stop_run();
    do_reset();
    write_at(1, 3'b100);
    stop_mode = 1'b1;
    @(negedge clk_sys); clk_run = 1'b0;
    repeat (4) @(negedge rc_clk);
    do_kick();
    check_expiry(BASE, "R5 runs in stop");
    clk_run = 1'b1; stop_mode = 1'b0;
    repeat (4) @(negedge clk_sys);
  endtask

  initial begin
    por_n = 1'b0; rst_ext_n = 1'b1; mode_wr = 1'b0; mode_wdata = '0;
    kick = 1'b0; stop_mode = 1'b0;
    t_por();
    t_selects();
    t_window();
    t_priority();
    t_stop_frozen();
    t_stop_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule